// File: doc/BRIEF.md
# Track Lifecycle Controller with M-of-N Scan History

This block keeps the lifecycle of a fixed pool of track slots for a multi-target tracker. Each slot is free, tentative or confirmed. Once per radar scan the upstream association stage hands it one scan record. The record holds a per-slot gate-hit mask and a count of new-target candidates, which are observations that matched no existing gate. The block applies the record to every slot in a single cycle. Tentative tracks are started in free slots. A tentative track becomes confirmed once it has enough recent hits. A track is dropped after a run of misses, and a tentative track is also dropped when it stays unconfirmed for too long.

Each slot keeps a short shift history of hit/miss outcomes, with the newest scan in the least significant position. The scan record arrives over a valid/ready handshake. After a record is accepted, the block reports every slot it started or dropped as a one-cycle strobe carrying the slot index. It reports one event per cycle and holds `scan_ready` low until the last event has been reported. This is the only back-pressure: an upstream stage that keeps `scan_valid` high simply waits, and its record is taken on the first cycle `scan_ready` is high. The pool size is a parameter. The default is 10 slots, and 20 slots builds from the same logic.

Top module: `track_life_ctrl`

## Requirements
- R1: After synchronous reset every slot reads free (code 00 in `slot_state`), `scan_ready` is 1, and `init_stb`, `del_stb` and `ovf_stb` are 0.
- R2: A scan record is taken on a rising edge where `scan_valid` and `scan_ready` are both 1. Slot states change only on such an edge. `scan_ready` stays 0 while events of the taken record are still being reported, and it returns to 1 in the cycle after the last event.
- R3: Candidates (`new_cnt`) fill slots that were free before the scan, lowest index first, one candidate per slot. Each filled slot becomes tentative (code 01). The starting observation counts as a hit in that slot's history.
- R4: Candidates beyond the number of free slots are dropped. `ovf_stb` is then 1 for exactly the one cycle after the record is taken; otherwise it stays 0.
- R5: A tentative slot becomes confirmed (code 10) on a scan after which at least 3 of its last 5 history entries are hits. Bit i of `hit_mask` is the hit for slot i.
- R6: A tentative slot that is still not confirmed at its fifth scan is freed and reported as a delete. The allocation scan counts as the first of the five.
- R7: A tentative or confirmed slot whose last 3 scans all had a 0 hit bit is freed (code 00) and reported as a delete.
- R8: Each start or drop is reported as a one-cycle `init_stb` or `del_stb`, never both at once, with the slot in `evt_slot`. Events of one record appear on consecutive cycles in strictly ascending slot order, with starts and drops merged into one sequence. The first event appears in the cycle after the record is taken.
- R9: Hit bits of free slots have no effect. A slot freed by a scan is not refilled in that same scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_valid | input | 1 | Scan record present |
| scan_ready | output | 1 | Block can take a scan record |
| hit_mask | input | NUM_SLOTS | Per-slot gate hit for this scan |
| new_cnt | input | clog2(NUM_SLOTS+1) | Number of new-target candidates |
| slot_state | output | 2*NUM_SLOTS | Per-slot state, 2 bits per slot: 00 free, 01 tentative, 10 confirmed |
| init_stb | output | 1 | A track was started in `evt_slot` |
| del_stb | output | 1 | A track was dropped from `evt_slot` |
| evt_slot | output | clog2(NUM_SLOTS) | Slot index of the current event |
| ovf_stb | output | 1 | Candidates were dropped because the pool was full |

## Verification
Starting a track and dropping a track can happen on the same scan. Their events then have to be merged into one ascending sequence, and the freshly freed slot must not be refilled. The bench sets this up by giving one tentative slot three straight misses while one new candidate is offered on the same scan. It then expects a delete on the lower slot, followed by a start on the next free slot above it, and not a start on the slot just freed. The recorded event order, the strobe kinds and the final state vector are all compared with values worked out by hand from the history rules.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'b00,
    SLOT_TENT = 2'b01,
    SLOT_CONF = 2'b10
  } slot_st_e;
endpackage

// File: rtl/trk_slot.sv
// One track slot: lifecycle state plus a short hit/miss history.
module trk_slot #(
  parameter int HIST_LEN   = 5,
  parameter int CONF_HITS  = 3,
  parameter int DEL_MISSES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             hit,
  input  logic             alloc,
  output trk_pkg::slot_st_e state,
  output logic             is_free,
  output logic             drop
);
  import trk_pkg::*;

  localparam int AGE_W = $clog2(HIST_LEN + 1);

  // Only HIST_LEN-1 older entries are stored; the current scan completes the window.
  logic [HIST_LEN-2:0] hist;
  logic [HIST_LEN-1:0] win;
  logic [AGE_W-1:0]    age, age_nx, hit_sum;
  logic                confirm, miss_run, timeout;

  assign win    = {hist, hit};
  assign age_nx = age + 1'b1;

  always_comb begin
    hit_sum = '0;
    for (int b = 0; b < HIST_LEN; b++) hit_sum = hit_sum + AGE_W'(win[b]);
  end

  assign confirm  = (hit_sum >= AGE_W'(CONF_HITS));
  assign miss_run = (win[DEL_MISSES-1:0] == '0);
  assign timeout  = (age_nx >= AGE_W'(HIST_LEN));
  assign is_free  = (state == SLOT_FREE);

  always_comb begin
    drop = 1'b0;
    if (upd) begin
      case (state)
        SLOT_TENT: drop = !confirm && (miss_run || timeout);
        SLOT_CONF: drop = miss_run;
        default:   drop = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SLOT_FREE;
      hist  <= '0;
      age   <= '0;
    end else if (upd) begin
      case (state)
        SLOT_FREE: begin
          if (alloc) begin
            state <= SLOT_TENT;
            hist  <= (HIST_LEN-1)'(1);
            age   <= AGE_W'(1);
          end
        end
        SLOT_TENT: begin
          if (confirm) begin
            state <= SLOT_CONF;
            hist  <= win[HIST_LEN-2:0];
          end else if (miss_run || timeout) begin
            state <= SLOT_FREE;
            hist  <= '0;
            age   <= '0;
          end else begin
            hist <= win[HIST_LEN-2:0];
            age  <= age_nx;
          end
        end
        SLOT_CONF: begin
          if (miss_run) begin
            state <= SLOT_FREE;
            hist  <= '0;
            age   <= '0;
          end else begin
            hist <= win[HIST_LEN-2:0];
          end
        end
        default: begin
          state <= SLOT_FREE;
          hist  <= '0;
          age   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/trk_alloc.sv
// Grants candidates to free slots in ascending index order.
module trk_alloc #(
  parameter int NUM_SLOTS = 10,
  localparam int CW = $clog2(NUM_SLOTS + 1)
) (
  input  logic [NUM_SLOTS-1:0] free_vec,
  input  logic [CW-1:0]        req_cnt,
  output logic [NUM_SLOTS-1:0] grant,
  output logic                 overflow
);
  logic [CW-1:0] rank;

  always_comb begin
    rank  = '0;
    grant = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      grant[i] = free_vec[i] && (rank < req_cnt);
      rank     = rank + CW'(free_vec[i]);
    end
    overflow = (req_cnt > rank);
  end
endmodule

// File: rtl/trk_evseq.sv
// Reports pending start/drop events one per cycle, lowest slot first.
module trk_evseq #(
  parameter int NUM_SLOTS = 10,
  localparam int IW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NUM_SLOTS-1:0] init_set,
  input  logic [NUM_SLOTS-1:0] del_set,
  output logic                 busy,
  output logic                 init_stb,
  output logic                 del_stb,
  output logic [IW-1:0]        idx
);
  logic [NUM_SLOTS-1:0] pend_i, pend_d, any, sel;
  logic                 found;

  assign any  = pend_i | pend_d;
  assign busy = |any;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    idx   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (any[i] && !found) begin
        found  = 1'b1;
        sel[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign init_stb = |(pend_i & sel);
  assign del_stb  = |(pend_d & sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_i <= '0;
      pend_d <= '0;
    end else if (load) begin
      pend_i <= init_set;
      pend_d <= del_set;
    end else begin
      pend_i <= pend_i & ~sel;
      pend_d <= pend_d & ~sel;
    end
  end
endmodule

// File: rtl/track_life_ctrl.sv
module track_life_ctrl #(
  parameter int NUM_SLOTS  = 10,
  parameter int HIST_LEN   = 5,
  parameter int CONF_HITS  = 3,
  parameter int DEL_MISSES = 3,
  localparam int CW = $clog2(NUM_SLOTS + 1),
  localparam int IW = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scan_valid,
  output logic                   scan_ready,
  input  logic [NUM_SLOTS-1:0]   hit_mask,
  input  logic [CW-1:0]          new_cnt,
  output logic [2*NUM_SLOTS-1:0] slot_state,
  output logic                   init_stb,
  output logic                   del_stb,
  output logic [IW-1:0]          evt_slot,
  output logic                   ovf_stb
);
  logic                 accept, busy, overflow;
  logic [NUM_SLOTS-1:0] free_vec, grant, drop_vec;

  assign scan_ready = !busy;
  assign accept     = scan_valid && scan_ready;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    trk_pkg::slot_st_e st;
    trk_slot #(
      .HIST_LEN  (HIST_LEN),
      .CONF_HITS (CONF_HITS),
      .DEL_MISSES(DEL_MISSES)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .upd    (accept),
      .hit    (hit_mask[g]),
      .alloc  (grant[g]),
      .state  (st),
      .is_free(free_vec[g]),
      .drop   (drop_vec[g])
    );
    assign slot_state[2*g +: 2] = st;
  end

  trk_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
    .free_vec(free_vec),
    .req_cnt (new_cnt),
    .grant   (grant),
    .overflow(overflow)
  );

  trk_evseq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .init_set(grant),
    .del_set (drop_vec),
    .busy    (busy),
    .init_stb(init_stb),
    .del_stb (del_stb),
    .idx     (evt_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_stb <= 1'b0;
    else     ovf_stb <= accept && overflow;
  end
endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
  parameter int NUM_SLOTS = 10,
  localparam int IW = $clog2(NUM_SLOTS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   scan_valid,
  input logic                   scan_ready,
  input logic [2*NUM_SLOTS-1:0] slot_state,
  input logic                   init_stb,
  input logic                   del_stb,
  input logic [IW-1:0]          evt_slot,
  input logic                   ovf_stb
);
  logic ev;
  assign ev = init_stb || del_stb;

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst) !(init_stb && del_stb)); // R8
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (ev && $past(ev)) |-> (evt_slot > $past(evt_slot))); // R8
  AST_INIT_TENT: assert property (@(posedge clk) disable iff (rst)
    init_stb |-> (slot_state[int'(evt_slot)*2 +: 2] == 2'b01)); // R3
  AST_DEL_FREE: assert property (@(posedge clk) disable iff (rst)
    del_stb |-> (slot_state[int'(evt_slot)*2 +: 2] == 2'b00)); // R7
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    !$past(scan_valid && scan_ready) |-> $stable(slot_state)); // R2
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    ovf_stb |-> $past(scan_valid && scan_ready)); // R4
endmodule

bind track_life_ctrl trk_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/track_life_ctrl_test.sv
module track_life_ctrl_test;
  localparam int N = 10;
  localparam int CW = 4;
  localparam int IW = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, scan_valid, scan_ready, init_stb, del_stb, ovf_stb;
  logic [N-1:0] hit_mask;
  logic [CW-1:0] new_cnt;
  logic [2*N-1:0] slot_state;
  logic [IW-1:0] evt_slot;

  int tests = 0, fails = 0;
  int rec_kind[64];
  int rec_slot[64];
  int n_ev;
  logic got_ovf, got_ready, busy_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  track_life_ctrl uut (
    .clk(clk), .rst(rst), .scan_valid(scan_valid), .scan_ready(scan_ready),
    .hit_mask(hit_mask), .new_cnt(new_cnt), .slot_state(slot_state),
    .init_stb(init_stb), .del_stb(del_stb), .evt_slot(evt_slot), .ovf_stb(ovf_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Offer one scan record, then log every event until the block is ready again.
  task automatic run_scan(input logic [N-1:0] hm, input logic [CW-1:0] cnt);
    @(negedge clk);
    chk(scan_ready == 1'b1, "R2", "ready before scan", scan_ready, 1);
    scan_valid = 1'b1; hit_mask = hm; new_cnt = cnt;
    @(negedge clk);
    scan_valid = 1'b0; hit_mask = '0; new_cnt = '0;
    got_ovf = ovf_stb; n_ev = 0; busy_bad = 1'b0;
    while ((init_stb || del_stb) && n_ev < 64) begin
      rec_kind[n_ev] = init_stb ? 1 : 2;
      rec_slot[n_ev] = int'(evt_slot);
      if (scan_ready || (init_stb && del_stb)) busy_bad = 1'b1;
      n_ev++;
      @(negedge clk);
    end
    got_ready = scan_ready;
  endtask

  task automatic check_events(input string req, input logic [N-1:0] exp_i,
                              input logic [N-1:0] exp_d, input logic exp_ovf);
    logic [N-1:0] gi, gd;
    bit asc;
    gi = '0; gd = '0; asc = 1'b1;
    for (int k = 0; k < n_ev; k++) begin
      if (rec_kind[k] == 1) gi[rec_slot[k]] = 1'b1;
      else                  gd[rec_slot[k]] = 1'b1;
      if (k > 0 && rec_slot[k] <= rec_slot[k-1]) asc = 1'b0;
    end
    chk(gi == exp_i, req, "init slots", gi, exp_i);
    chk(gd == exp_d, req, "delete slots", gd, exp_d);
    chk(n_ev == $countones(exp_i | exp_d), "R8", "event count", n_ev, $countones(exp_i | exp_d));
    chk(asc, "R8", "ascending order", asc, 1);
    chk(!busy_bad, "R2", "ready low while reporting", busy_bad, 0);
    chk(got_ready == 1'b1, "R2", "ready after events", got_ready, 1);
    chk(got_ovf == exp_ovf, "R4", "overflow strobe", got_ovf, exp_ovf);
  endtask

  task automatic chk_state(input string req, input logic [2*N-1:0] es);
    chk(slot_state == es, req, "slot states", slot_state, es);
  endtask

  task automatic t_reset;
    rst = 1'b1; scan_valid = 1'b0; hit_mask = '0; new_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(slot_state == '0, "R1", "states after reset", slot_state, 0);
    chk(scan_ready == 1'b1, "R1", "ready after reset", scan_ready, 1);
    chk({init_stb, del_stb, ovf_stb} == 3'b000, "R1", "strobes after reset",
        {init_stb, del_stb, ovf_stb}, 0);
  endtask

  // R3: three candidates land in slots 0..2.
  task automatic t_alloc;
    logic [2*N-1:0] es;
    run_scan('0, 4'd3);
    check_events("R3", 10'b0000000111, '0, 1'b0);
    es = '0; es[1:0] = 2'b01; es[3:2] = 2'b01; es[5:4] = 2'b01;
    chk_state("R3", es);
  endtask

  // R5 + R9: slot 0 confirms on three hits, hit on free slot 7 has no effect.
  task automatic t_confirm;
    logic [2*N-1:0] es;
    run_scan(10'b0000000001, 4'd0);
    check_events("R5", '0, '0, 1'b0);
    es = '0; es[1:0] = 2'b01; es[3:2] = 2'b01; es[5:4] = 2'b01;
    chk_state("R5", es);
    run_scan(10'b0010000011, 4'd0);
    check_events("R9", '0, '0, 1'b0);
    es = '0; es[1:0] = 2'b10; es[3:2] = 2'b01; es[5:4] = 2'b01;
    chk_state("R5", es);
  endtask

  // R7 + R9: slot 2 drops on its third miss while one candidate goes to slot 3.
  task automatic t_same_scan;
    logic [2*N-1:0] es;
    run_scan(10'b0000000001, 4'd1);
    check_events("R9", 10'b0000001000, 10'b0000000100, 1'b0);
    es = '0; es[1:0] = 2'b10; es[3:2] = 2'b01; es[7:6] = 2'b01;
    chk_state("R7", es);
  endtask

  // R6: slot 1 (alloc, miss, hit, miss, miss) times out unconfirmed.
  task automatic t_timeout;
    logic [2*N-1:0] es;
    run_scan(10'b0000001000, 4'd0);
    check_events("R6", '0, 10'b0000000010, 1'b0);
    es = '0; es[1:0] = 2'b10; es[7:6] = 2'b01;
    chk_state("R6", es);
  endtask

  // R7: confirmed slot 0 drops after its third consecutive miss.
  task automatic t_conf_drop;
    logic [2*N-1:0] es;
    run_scan(10'b0000001000, 4'd0);
    check_events("R7", '0, '0, 1'b0);
    es = '0; es[1:0] = 2'b10; es[7:6] = 2'b10;
    chk_state("R7", es);
    run_scan(10'b0000001000, 4'd0);
    check_events("R7", '0, 10'b0000000001, 1'b0);
    es = '0; es[7:6] = 2'b10;
    chk_state("R7", es);
  endtask

  // R4: more candidates than free slots, then a full pool.
  task automatic t_overflow;
    logic [2*N-1:0] es;
    run_scan(10'b0000001000, 4'd15);
    check_events("R4", 10'b1111110111, '0, 1'b1);
    es = {N{2'b01}}; es[7:6] = 2'b10;
    chk_state("R4", es);
    run_scan({N{1'b1}}, 4'd2);
    check_events("R4", '0, '0, 1'b1);
    chk_state("R4", es);
    @(negedge clk);
    chk(ovf_stb == 1'b0, "R4", "overflow single cycle", ovf_stb, 0);
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_confirm();
    t_same_scan();
    t_timeout();
    t_conf_drop();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule